// File: doc/BRIEF.md
# Stacked Register Window Renamer

This block keeps the current procedure's view of a stacked general register file and translates logical register numbers into physical slot indices. Its state is a frame marker holding a local-area size, an output-area size, a rotating-area size and a rotation count, plus a physical base pointer into a ring of stacked slots. Commands arrive one per cycle: call, return, allocate and rotate. A call opens a callee frame whose local area is empty and whose output area sits on the same physical registers as the caller's outputs, so arguments pass without copying. A return brings back the caller's full marker from an internal marker stack.

Every cycle, each of several lookup ports presents a logical register number and receives, one cycle later, a unified physical index: static registers map to themselves, and stacked registers map to 32 plus a slot in the ring. Accesses beyond the current frame are flagged. One-cycle pulses report an illegal allocate, an overflow (frame depth beyond the ring capacity, or a call with the marker stack full) and an underflow (a return with nothing to return to). Spilling to memory, data storage and deferred-exception tags lie outside the block.

Top module: `regframe_alloc`

## Requirements
- R1: A logical number below 32 comes out unchanged as the index, with the out-of-frame bit low.
- R2: A logical number 32+k with k below local plus output size and outside the rotating area maps to 32 + ((base + k) mod CAP).
- R3: A logical number 32+k with k at or beyond local plus output size gives index 0 with the out-of-frame bit high.
- R4: Op code 1 (call), when the marker stack holds fewer than DEPTH entries, pushes the marker, advances base by the caller's local size modulo CAP, and leaves a frame with local size 0, the caller's output size, rotating size 0 and rotation count 0.
- R5: Op code 2 (return) restores the most recent pushed marker and moves base back by that marker's local size modulo CAP; with an empty stack it changes nothing and pulses the underflow output.
- R6: Op code 3 (allocate) with legal operands sets local, output and rotating sizes from the allocate inputs and clears the rotation count.
- R7: An allocate whose local plus output exceeds 96, whose rotating size exceeds local plus output, or whose rotating size is not a multiple of 8 leaves the marker unchanged and pulses the illegal output.
- R8: The overflow output pulses for a legal allocate that makes the sum of all pushed local sizes plus the new frame size exceed CAP (the allocate still takes effect), and for a call with DEPTH entries stacked (the call is dropped).
- R9: Op code 4 (rotate) increments the rotation count modulo the rotating size and does nothing when that size is 0; inside the rotating area offset k uses slot (k − count) mod rotating size before the base is added.
- R10: Physical slots wrap modulo CAP, so a frame running past the top of the ring continues at slot 0.
- R11: Indices and pulses are registered: the result for inputs presented in one cycle appears after the next clock edge, computed with the marker as it was before any command in that same cycle; op code 0 does nothing.
- R12: After synchronous reset, all outputs are 0, the frame is empty and base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_op | input | 3 | Command: 0 none, 1 call, 2 return, 3 allocate, 4 rotate |
| i_alloc_loc | input | 7 | Local size for allocate |
| i_alloc_out | input | 7 | Output size for allocate |
| i_alloc_rot | input | 7 | Rotating size for allocate |
| i_lreg | input | NPORTS*7 | Logical register numbers, port p at bits [7p+6:7p] |
| o_pidx | output | NPORTS*PIDX_W | Physical indices, port p at bits [PIDX_W*p+PIDX_W-1:PIDX_W*p] |
| o_oof | output | NPORTS | Out-of-frame bit per port |
| o_ovf | output | 1 | Overflow pulse |
| o_unf | output | 1 | Underflow pulse |
| o_ill | output | 1 | Illegal-allocate pulse |

## Verification
The lookup ports are exercised with static numbers, numbers inside the local area, inside the output area just after a call, and one past the frame end, which separates passthrough, base offsetting, caller-callee overlay and the frame boundary. Rotation is driven through several increments and a full wrap of the count, which distinguishes a correct modulo from an off-by-one in direction. A frame that straddles the top of the ring, a chain of calls that fills the marker stack and unwinds again, and the three kinds of illegal allocate tell apart wraparound, push/pop ordering and the rejection paths. Lookups issued in the same cycle as a command show that the mapping uses the marker from before that command.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int LREG_W      = 7;
  localparam int SZ_W        = 7;
  localparam int STATIC_REGS = 32;
  localparam int MAX_FRAME   = 96;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CALL  = 3'd1,
    OP_RET   = 3'd2,
    OP_ALLOC = 3'd3,
    OP_ROT   = 3'd4
  } op_e;

  typedef struct packed {
    logic [SZ_W-1:0] loc;
    logic [SZ_W-1:0] out;
    logic [SZ_W-1:0] rot;
    logic [SZ_W-1:0] rrb;
  } marker_t;
endpackage

// File: rtl/regframe_mstack.sv
module regframe_mstack
  import regframe_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  logic    pop,
  input  marker_t wdata,
  output marker_t top,
  output logic    full,
  output logic    empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  marker_t        mem [DEPTH];
  logic [PW-1:0]  sp_q;
  logic [PW-1:0]  spm1;

  assign spm1  = sp_q - 1'b1;
  assign top   = mem[spm1[AW-1:0]];
  assign full  = (sp_q == PW'(DEPTH));
  assign empty = (sp_q == '0);

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[sp_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + 1'b1;
    else if (pop)  sp_q <= sp_q - 1'b1;
  end

  a_r8_sp_bound: assert property (@(posedge clk) disable iff (rst)
    int'(sp_q) <= DEPTH);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
endmodule

// File: rtl/regframe_ctrl.sv
module regframe_ctrl
  import regframe_pkg::*;
#(
  parameter int CAP    = 96,
  parameter int DEPTH  = 8,
  parameter int BASE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [SZ_W-1:0]   a_loc,
  input  logic [SZ_W-1:0]   a_out,
  input  logic [SZ_W-1:0]   a_rot,
  output marker_t           cur,
  output logic [BASE_W-1:0] base,
  output logic              ovf,
  output logic              unf,
  output logic              ill
);
  localparam int USED_W = $clog2((DEPTH + 1) * MAX_FRAME + 1);
  localparam int SW     = USED_W + 1;
  localparam int BW1    = BASE_W + 1;

  marker_t            cur_q, cur_d, top;
  logic [BASE_W-1:0]  base_q, base_d;
  logic [USED_W-1:0]  used_q, used_d;
  logic               push, pop, full, empty;
  logic               ovf_d, unf_d, ill_d;
  logic [7:0]         tot;
  logic               bad;
  logic [SW-1:0]      need;
  logic [BW1-1:0]     bsum;
  logic [SZ_W-1:0]    rrb_inc;

  regframe_mstack #(.DEPTH(DEPTH)) u_mstack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (cur_q),
    .top   (top),
    .full  (full),
    .empty (empty)
  );

  always_comb begin
    cur_d   = cur_q;
    base_d  = base_q;
    used_d  = used_q;
    push    = 1'b0;
    pop     = 1'b0;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    ill_d   = 1'b0;
    tot     = {1'b0, a_loc} + {1'b0, a_out};
    bad     = (tot > 8'(MAX_FRAME)) || ({1'b0, a_rot} > tot) || (a_rot[2:0] != 3'd0);
    need    = SW'(used_q) + SW'(tot);
    bsum    = '0;
    rrb_inc = cur_q.rrb + 1'b1;
    case (op)
      OP_CALL: begin
        if (full) begin
          ovf_d = 1'b1;
        end else begin
          push = 1'b1;
          bsum = BW1'(base_q) + BW1'(cur_q.loc);
          if (bsum >= BW1'(CAP)) bsum = bsum - BW1'(CAP);
          base_d = bsum[BASE_W-1:0];
          used_d = used_q + USED_W'(cur_q.loc);
          cur_d  = '{loc: '0, out: cur_q.out, rot: '0, rrb: '0};
        end
      end
      OP_RET: begin
        if (empty) begin
          unf_d = 1'b1;
        end else begin
          pop  = 1'b1;
          bsum = BW1'(base_q) + BW1'(CAP) - BW1'(top.loc);
          if (bsum >= BW1'(CAP)) bsum = bsum - BW1'(CAP);
          base_d = bsum[BASE_W-1:0];
          used_d = used_q - USED_W'(top.loc);
          cur_d  = top;
        end
      end
      OP_ALLOC: begin
        if (bad) begin
          ill_d = 1'b1;
        end else begin
          ovf_d = (need > SW'(CAP));
          cur_d = '{loc: a_loc, out: a_out, rot: a_rot, rrb: '0};
        end
      end
      OP_ROT: begin
        if (cur_q.rot != '0)
          cur_d.rrb = (rrb_inc == cur_q.rot) ? '0 : rrb_inc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      base_q <= '0;
      used_q <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      ill    <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      base_q <= base_d;
      used_q <= used_d;
      ovf    <= ovf_d;
      unf    <= unf_d;
      ill    <= ill_d;
    end
  end

  assign cur  = cur_q;
  assign base = base_q;

  a_r4_call_empty_local: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CALL && !full) |=> (cur_q.loc == '0 && cur_q.out == $past(cur_q.out) && cur_q.rot == '0));
  a_r5_underflow_keeps: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RET && empty) |=> (unf && $stable(cur_q) && $stable(base_q)));
  a_r7_illegal_keeps: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ALLOC && bad) |=> (ill && $stable(cur_q) && $stable(base_q)));
  a_r8_full_call_dropped: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CALL && full) |=> (ovf && $stable(cur_q) && $stable(base_q)));
  a_r9_rrb_in_range: assert property (@(posedge clk) disable iff (rst)
    (cur_q.rot == '0) ? (cur_q.rrb == '0) : (cur_q.rrb < cur_q.rot));
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf, unf, ill}));
endmodule

// File: rtl/regframe_rename.sv
module regframe_rename
  import regframe_pkg::*;
#(
  parameter int CAP    = 96,
  parameter int BASE_W = 7,
  parameter int PIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LREG_W-1:0] lreg,
  input  marker_t           cur,
  input  logic [BASE_W-1:0] base,
  output logic [PIDX_W-1:0] idx,
  output logic              oof
);
  localparam int PW = BASE_W + 1;

  logic [7:0]        off, size, rot8, t, roff;
  logic [PW-1:0]     p;
  logic              stat, outf;
  logic [PIDX_W-1:0] idx_d;

  always_comb begin
    stat = (lreg < LREG_W'(STATIC_REGS));
    off  = {1'b0, lreg} - 8'(STATIC_REGS);
    size = {1'b0, cur.loc} + {1'b0, cur.out};
    rot8 = {1'b0, cur.rot};
    outf = !stat && (off >= size);
    t    = off + rot8 - {1'b0, cur.rrb};
    if (t >= rot8) t = t - rot8;
    roff = (off < rot8) ? t : off;
    p    = PW'(base) + PW'(roff);
    if (p >= PW'(CAP)) p = p - PW'(CAP);
    if (stat)      idx_d = PIDX_W'(lreg);
    else if (outf) idx_d = '0;
    else           idx_d = PIDX_W'(STATIC_REGS) + PIDX_W'(p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      oof <= 1'b0;
    end else begin
      idx <= idx_d;
      oof <= outf;
    end
  end

  a_r1_static_pass: assert property (@(posedge clk) disable iff (rst)
    (lreg < LREG_W'(STATIC_REGS)) |=> (idx == PIDX_W'($past(lreg)) && !oof));
  a_r3_oof_zero: assert property (@(posedge clk) disable iff (rst)
    oof |-> (idx == '0));
  a_r10_idx_range: assert property (@(posedge clk) disable iff (rst)
    int'(idx) < STATIC_REGS + CAP);
endmodule

// File: rtl/regframe_alloc.sv
module regframe_alloc
  import regframe_pkg::*;
#(
  parameter int CAP    = 96,
  parameter int DEPTH  = 8,
  parameter int NPORTS = 2,
  localparam int BASE_W = $clog2(CAP),
  localparam int PIDX_W = $clog2(STATIC_REGS + CAP)
) (
  input  logic                       i_clk,
  input  logic                       i_rst,
  input  logic [2:0]                 i_op,
  input  logic [SZ_W-1:0]            i_alloc_loc,
  input  logic [SZ_W-1:0]            i_alloc_out,
  input  logic [SZ_W-1:0]            i_alloc_rot,
  input  logic [NPORTS*LREG_W-1:0]   i_lreg,
  output logic [NPORTS*PIDX_W-1:0]   o_pidx,
  output logic [NPORTS-1:0]          o_oof,
  output logic                       o_ovf,
  output logic                       o_unf,
  output logic                       o_ill
);
  marker_t           cur;
  logic [BASE_W-1:0] base;

  regframe_ctrl #(.CAP(CAP), .DEPTH(DEPTH), .BASE_W(BASE_W)) u_ctrl (
    .clk   (i_clk),
    .rst   (i_rst),
    .op    (op_e'(i_op)),
    .a_loc (i_alloc_loc),
    .a_out (i_alloc_out),
    .a_rot (i_alloc_rot),
    .cur   (cur),
    .base  (base),
    .ovf   (o_ovf),
    .unf   (o_unf),
    .ill   (o_ill)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    regframe_rename #(.CAP(CAP), .BASE_W(BASE_W), .PIDX_W(PIDX_W)) u_rename (
      .clk  (i_clk),
      .rst  (i_rst),
      .lreg (i_lreg[g*LREG_W +: LREG_W]),
      .cur  (cur),
      .base (base),
      .idx  (o_pidx[g*PIDX_W +: PIDX_W]),
      .oof  (o_oof[g])
    );
  end
endmodule

// File: tb/regframe_alloc_bench.sv
module regframe_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CAP   = 96;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = '0;
  logic [6:0]  aloc = '0, aout = '0, arot = '0;
  logic [13:0] lreg = '0;
  logic [13:0] pidx;
  logic [1:0]  oof;
  logic        ovf, unf, ill;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_loc = 0, m_out = 0, m_rot = 0, m_rrb = 0, m_base = 0, m_used = 0;
  int q_loc[$], q_out[$], q_rot[$], q_rrb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regframe_alloc u_regframe_alloc (
    .i_clk(clk), .i_rst(rst), .i_op(op),
    .i_alloc_loc(aloc), .i_alloc_out(aout), .i_alloc_rot(arot),
    .i_lreg(lreg), .o_pidx(pidx), .o_oof(oof),
    .o_ovf(ovf), .o_unf(unf), .o_ill(ill)
  );

  // returns -1 for an out-of-frame access
  function automatic int ref_map(int r);
    int off, roff;
    if (r < 32) return r;
    off = r - 32;
    if (off >= m_loc + m_out) return -1;
    if (off < m_rot) roff = (((off - m_rrb) % m_rot) + m_rot) % m_rot;
    else roff = off;
    return 32 + (m_base + roff) % CAP;
  endfunction

  task automatic step(input string tag, input int c, input int a, input int b,
                      input int r, input int l0, input int l1);
    int e0, e1, eo, eu, ei, t, pl;
    op = 3'(c); aloc = 7'(a); aout = 7'(b); arot = 7'(r);
    lreg = {7'(l1), 7'(l0)};
    e0 = ref_map(l0); e1 = ref_map(l1);
    eo = 0; eu = 0; ei = 0;
    case (c)
      1: if (q_loc.size() == DEPTH) eo = 1;
         else begin
           q_loc.push_back(m_loc); q_out.push_back(m_out);
           q_rot.push_back(m_rot); q_rrb.push_back(m_rrb);
           m_base = (m_base + m_loc) % CAP; m_used += m_loc;
           m_loc = 0; m_rot = 0; m_rrb = 0;
         end
      2: if (q_loc.size() == 0) eu = 1;
         else begin
           pl = q_loc.pop_back();
           m_base = (m_base - pl + CAP) % CAP; m_used -= pl;
           m_loc = pl; m_out = q_out.pop_back();
           m_rot = q_rot.pop_back(); m_rrb = q_rrb.pop_back();
         end
      3: begin
           t = a + b;
           if (t > 96 || r > t || r % 8 != 0) ei = 1;
           else begin
             if (m_used + t > CAP) eo = 1;
             m_loc = a; m_out = b; m_rot = r; m_rrb = 0;
           end
         end
      4: if (m_rot > 0) m_rrb = (m_rrb + 1) % m_rot;
      default: ;
    endcase
    @(negedge clk);
    vectors++;
    if (int'(pidx[6:0]) != (e0 < 0 ? 0 : e0) || oof[0] != (e0 < 0) ||
        int'(pidx[13:7]) != (e1 < 0 ? 0 : e1) || oof[1] != (e1 < 0) ||
        ovf != eo[0] || unf != eu[0] || ill != ei[0]) begin
      errors++;
      $display("FAIL %s: idx0=%0d oof0=%0d idx1=%0d oof1=%0d ovf=%0d unf=%0d ill=%0d expected idx0=%0d oof0=%0d idx1=%0d oof1=%0d ovf=%0d unf=%0d ill=%0d",
               tag, pidx[6:0], oof[0], pidx[13:7], oof[1], ovf, unf, ill,
               (e0 < 0 ? 0 : e0), (e0 < 0), (e1 < 0 ? 0 : e1), (e1 < 0), eo, eu, ei);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state seen before any command takes effect
    vectors++;
    if (pidx != '0 || oof != '0 || ovf || unf || ill) begin
      errors++;
      $display("FAIL R12: pidx=%0h oof=%0b flags=%0b%0b%0b expected all zero", pidx, oof, ovf, unf, ill);
    end
    step("R1_R3", 0, 0, 0, 0, 5, 40);        // static passes, empty frame is out of range
    step("R11", 3, 10, 6, 0, 33, 31);         // lookup uses pre-allocate marker
    step("R2", 0, 0, 0, 0, 33, 47);           // inside frame
    step("R3", 0, 0, 0, 0, 48, 0);            // one past frame end
    step("R11", 1, 0, 0, 0, 42, 32);          // call; mapping still caller's
    step("R4", 0, 0, 0, 0, 32, 37);           // overlay on caller outputs
    step("R4", 0, 0, 0, 0, 38, 12);           // callee local area empty
    step("R6", 3, 20, 4, 16, 32, 55);
    step("R9", 4, 0, 0, 0, 32, 47);
    step("R9", 4, 0, 0, 0, 32, 47);
    step("R9", 4, 0, 0, 0, 32, 50);
    step("R9", 0, 0, 0, 0, 32, 47);
    for (int i = 0; i < 13; i++) step("R9", 4, 0, 0, 0, 32, 40);
    step("R9", 0, 0, 0, 0, 32, 47);           // count wrapped to zero
    step("R7", 3, 90, 10, 0, 32, 33);         // too large
    step("R7", 3, 2, 2, 8, 32, 33);           // rotating exceeds frame
    step("R7", 3, 20, 4, 12, 32, 33);         // not a multiple of 8
    step("R7", 0, 0, 0, 0, 55, 56);           // marker untouched
    step("R5", 2, 0, 0, 0, 32, 47);
    step("R5", 0, 0, 0, 0, 47, 48);
    step("R5", 2, 0, 0, 0, 32, 33);           // empty stack underflow
    step("R5", 0, 0, 0, 0, 47, 33);
    step("R6", 3, 90, 6, 0, 32, 127);
    step("R10", 1, 0, 0, 0, 121, 122);
    step("R8", 3, 20, 0, 0, 32, 37);          // depth 110 > 96
    step("R10", 0, 0, 0, 0, 40, 51);          // straddles ring top
    step("R9", 4, 0, 0, 0, 40, 52);           // no rotating area
    for (int i = 0; i < 7; i++) step("R4", 1, 0, 0, 0, 32, 37);
    step("R8", 1, 0, 0, 0, 32, 37);           // stack full
    step("R8", 0, 0, 0, 0, 32, 37);
    for (int i = 0; i < 8; i++) step("R5", 2, 0, 0, 0, 32, 40);
    step("R10", 0, 0, 0, 0, 121, 127);
    step("R2", 3, 8, 8, 8, 35, 44);
    step("R9", 4, 0, 0, 0, 32, 39);
    step("R9", 0, 0, 0, 0, 32, 39);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule